// File: doc/BRIEF.md
# Serial PHY Management Frame Master

This block runs PHY register reads and writes over a two-wire management link made of a clock output and a shared data line. A host puts a command on the command inputs and raises a start strobe for one cycle. The command selects read or write and gives a 5-bit PHY address, a 5-bit register address and, for writes, 16 data bits. The block then builds the whole serial frame and shifts it out on a management clock that it derives from the system clock. The 32-bit preamble can be switched off for each command.

During a read the block stops driving the data line at the turnaround field. It takes the 16 bits that the PHY returns and shows them on the read-data output when the frame ends. A busy flag covers the whole transaction. A one-cycle done pulse marks the end of it. The data line is driven through a separate output-enable so that a tri-state pad can float it whenever the master is not driving.

Top module: `mdio_master`

## Requirements
- R1: While reset is held and in the cycle after it is released, `busy`, `done`, `mdc` and `mdio_oe` are all low.
- R2: While a frame runs, `mdc` has a period of exactly `CLK_DIV` system cycles, with equal high and low halves. While `busy` is low, `mdc` stays low.
- R3: With `cmd_no_pre` low, a frame has 64 bit periods and the first 32 bits are ones. With `cmd_no_pre` high, the preamble is left out and a frame has 32 bit periods.
- R4: After the preamble come the start bits 0 then 1 and the opcode. The opcode is 1,0 for a read (`cmd_read`=1) and 0,1 for a write. Then come the PHY address and the register address, each 5 bits, most significant bit first. All of these bits are driven.
- R5: In a write, the turnaround is driven as 1 then 0, followed by `cmd_wdata` most significant bit first, with `mdio_oe` high throughout.
- R6: In a read, `mdio_oe` is low for both turnaround bits and all 16 data bits. The master samples `mdio_i` at each of the 16 data-bit rising edges of `mdc`, most significant bit first. The result appears on `rd_data` in the cycle in which `done` is high.
- R7: While a frame is in progress, `mdio_o` changes only at the system edge where `mdc` falls, so each bit is stable across the PHY's rising-edge sample.
- R8: `done` is high for exactly one cycle. It is high N·`CLK_DIV` cycles after the edge that accepted the command, where N is the frame's bit count. `busy` is high from acceptance until that cycle and low in it.
- R9: A start strobe that arrives while `busy` is high is ignored. The running frame's bits and its length do not change, and no second frame follows.
- R10: `mdio_oe` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | One-cycle command strobe, accepted only when idle |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write data |
| cmd_no_pre | input | 1 | 1 = leave out the 32-bit preamble |
| mdio_i | input | 1 | Data line as seen at the pad |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 16 | Data captured by the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data driven toward the pad |
| mdio_oe | output | 1 | Pad output enable |

## Verification
The hardest case to reach is the hand-off of the data line in a read. The bench must act as the PHY: it releases the line, then returns a data bit on each management clock edge. It must also check that the master has stopped driving from exactly the first turnaround bit onward. The bench does this with a PHY model that counts `mdc` rising edges from the start of the frame. After each rising edge it places the next expected response bit on `mdio_i`, and at each rising edge it checks the enable and the driven bit against a frame it builds arithmetically. A second hard case is a start strobe that arrives in the middle of a frame. The sweep injects one partway through some frames, using a conflicting command, and then confirms that the bit stream and the done timing are unchanged.

// File: rtl/mdio_pkg.sv
// Shared definitions for the serial PHY management master.
// Assumes a frame indexed 0..63, preamble at 0..31 and frame body at 32..63.
package mdio_pkg;

    localparam logic [1:0] MGMT_START   = 2'b01;
    localparam logic [1:0] MGMT_OP_RD   = 2'b10;
    localparam logic [1:0] MGMT_OP_WR   = 2'b01;
    localparam logic [1:0] MGMT_TA_WR   = 2'b10;
    localparam logic [1:0] MGMT_TA_RD   = 2'b11;

    // Bit index of the first body bit, first turnaround bit and first data bit.
    localparam logic [5:0] BODY_IDX     = 6'd32;
    localparam logic [5:0] TA_IDX       = 6'd46;
    localparam logic [5:0] DATA_IDX     = 6'd48;
    localparam logic [5:0] LAST_IDX     = 6'd63;

    typedef struct packed {
        logic       rd;
        logic [4:0] phy;
        logic [4:0] regad;
        logic [15:0] wdata;
    } mgmt_cmd_t;

endpackage

// File: rtl/mdio_clkgen.sv
// Management clock generator.
// Divides the system clock by the even ratio DIV while run is high and gives
// one-cycle strobes in the cycle before each mdc edge. mdc is held low and
// the phase counter is cleared while run is low, so every frame begins with
// a full low half period.
module mdio_clkgen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);

    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] PHASE_END = CW'(HALF - 1);

    logic [CW-1:0] phase_q;
    logic          wrap;

    // The half period ends when the phase counter reaches its last value.
    assign wrap     = run && (phase_q == PHASE_END);
    assign rise_stb = wrap && !mdc;
    assign fall_stb = wrap && mdc;

    // Phase counter and clock toggle; forced idle when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_q <= '0;
            mdc     <= 1'b0;
        end else if (wrap) begin
            phase_q <= '0;
            mdc     <= !mdc;
        end else begin
            phase_q <= phase_q + CW'(1);
        end
    end

    // R2: once run drops, the clock is low from the next cycle on.
    p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);

endmodule

// File: rtl/mdio_frame_build.sv
// Assembles the complete 64-bit management frame from a command.
// Pure combinational; bit 63 is sent first. For reads the turnaround and
// data positions hold filler that is never driven onto the line.
module mdio_frame_build
    import mdio_pkg::*;
(
    input  mgmt_cmd_t   cmd,
    output logic [63:0] frame
);

    // Concatenate preamble, start, opcode, addresses, turnaround and data.
    always_comb begin
        frame = {32'hFFFF_FFFF,
                 MGMT_START,
                 cmd.rd ? MGMT_OP_RD : MGMT_OP_WR,
                 cmd.phy,
                 cmd.regad,
                 cmd.rd ? MGMT_TA_RD : MGMT_TA_WR,
                 cmd.rd ? 16'h0000 : cmd.wdata};
    end

endmodule

// File: rtl/mdio_sequencer.sv
// Frame sequencer.
// Accepts a command when idle and latches the assembled frame. It presents
// one bit per mdc period, moving on at each falling-edge strobe, and
// releases the line for the read turnaround and read data. It samples
// returned bits on rising-edge strobes and closes the frame with a done
// pulse. Assumes the strobes come from a clock generator that runs while
// busy is high.
module mdio_sequencer
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        cmd_rd,
    input  logic        no_pre,
    input  logic [63:0] frame,
    input  logic        rise_stb,
    input  logic        fall_stb,
    input  logic        mdio_i,
    output logic        busy,
    output logic        done,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rd_data
);

    logic [5:0]  idx_q;
    logic [63:0] frame_q;
    logic        rd_q;
    logic [15:0] shift_q;
    logic        accept;
    logic [5:0]  first_idx;
    logic [5:0]  idx_nx;

    assign accept    = start && !busy;
    assign first_idx = no_pre ? BODY_IDX : 6'd0;
    assign idx_nx    = idx_q + 6'd1;

    // Whether the master drives the line for a given bit index.
    function automatic logic drives(input logic [5:0] i, input logic rd);
        return (i < TA_IDX) || !rd;
    endfunction

    // Command acceptance, bit stepping on falling strobes, frame close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
            idx_q   <= '0;
            frame_q <= '0;
            rd_q    <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy    <= 1'b1;
                frame_q <= frame;
                rd_q    <= cmd_rd;
                idx_q   <= first_idx;
                mdio_o  <= frame[LAST_IDX - first_idx];
                mdio_oe <= 1'b1;
            end else if (busy && fall_stb) begin
                if (idx_q == LAST_IDX) begin
                    busy    <= 1'b0;
                    done    <= 1'b1;
                    mdio_o  <= 1'b0;
                    mdio_oe <= 1'b0;
                    if (rd_q) begin
                        rd_data <= shift_q;
                    end
                end else begin
                    idx_q   <= idx_nx;
                    mdio_o  <= frame_q[LAST_IDX - idx_nx];
                    mdio_oe <= drives(idx_nx, rd_q);
                end
            end
        end
    end

    // Read capture: shift in one returned bit per data-bit rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (busy && rise_stb && rd_q && (idx_q >= DATA_IDX)) begin
            shift_q <= {shift_q[14:0], mdio_i};
        end
    end

    // R8: done lasts a single cycle.
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: done closes a busy period and busy is low in that cycle.
    p_done_closes_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R10: the pad is never enabled while idle.
    p_idle_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    // R6: during read turnaround and data the line stays released.
    p_read_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_q && (idx_q >= TA_IDX)) |-> !mdio_oe);

endmodule

// File: rtl/mdio_master.sv
// Serial PHY management frame master, top level.
// Ties the clock generator, the frame builder and the sequencer together.
// Assumes CLK_DIV is even and at least 2, and that cmd_start is a strobe
// that only counts when busy is low.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_start,
    input  logic        cmd_read,
    input  logic [4:0]  cmd_phy,
    input  logic [4:0]  cmd_reg,
    input  logic [15:0] cmd_wdata,
    input  logic        cmd_no_pre,
    input  logic        mdio_i,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe
);

    mgmt_cmd_t   cmd;
    logic [63:0] frame;
    logic        rise_stb;
    logic        fall_stb;

    // Gather the command ports into one record.
    always_comb begin
        cmd.rd    = cmd_read;
        cmd.phy   = cmd_phy;
        cmd.regad = cmd_reg;
        cmd.wdata = cmd_wdata;
    end

    mdio_frame_build u_build (
        .cmd   (cmd),
        .frame (frame)
    );

    mdio_clkgen #(.DIV(CLK_DIV)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_sequencer u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cmd_start),
        .cmd_rd   (cmd_read),
        .no_pre   (cmd_no_pre),
        .frame    (frame),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .done     (done),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_data  (rd_data)
    );

    // R2: the management clock is low whenever no transaction is active.
    p_idle_clock_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R7: during a frame the driven bit moves only together with a falling mdc.
    p_data_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && (mdio_o != $past(mdio_o))) |-> $fell(mdc));

endmodule

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
// Sweep bench: acts as host and as PHY, rebuilds every frame arithmetically.
module mdio_master_test;

    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic        cmd_read = 1'b0;
    logic [4:0]  cmd_phy = '0;
    logic [4:0]  cmd_reg = '0;
    logic [15:0] cmd_wdata = '0;
    logic        cmd_no_pre = 1'b0;
    logic        mdio_i = 1'b1;
    logic        busy, done, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    mdio_master #(.CLK_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_read(cmd_read),
        .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
        .cmd_no_pre(cmd_no_pre), .mdio_i(mdio_i), .busy(busy), .done(done),
        .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp_v);
        end
    endtask

    // One transaction with a PHY model; poke injects a start while busy (R9).
    task automatic run_frame(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] wd, input logic [15:0] rsp,
                             input logic np, input logic poke);
        logic [63:0] exp_bits;
        int first, nbits, cyc, rises, bad, bad_per, last_rise, p, q;
        logic prev_mdc, seen_done, busy_gap, exp_oe;
        exp_bits = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, pa, ra, 2'b10, wd};
        first = np ? 32 : 0;
        nbits = 64 - first;
        cyc = 0; rises = 0; bad = 0; bad_per = 0; last_rise = 0;
        seen_done = 1'b0; busy_gap = 1'b0;
        @(negedge clk);
        cmd_read = rd; cmd_phy = pa; cmd_reg = ra; cmd_wdata = wd;
        cmd_no_pre = np; cmd_start = 1'b1; mdio_i = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        prev_mdc = mdc;
        while (!seen_done && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 9) begin
                cmd_read = !rd; cmd_phy = ~pa; cmd_reg = ~ra; cmd_wdata = ~wd;
                cmd_no_pre = !np; cmd_start = 1'b1;
            end
            if (poke && cyc == 10) cmd_start = 1'b0;
            if (mdc && !prev_mdc) begin
                p = first + rises;
                exp_oe = (p < 46) || !rd;
                if (mdio_oe !== exp_oe) bad++;
                else if (exp_oe && (mdio_o !== exp_bits[63 - p])) bad++;
                if (rises > 0 && (cyc - last_rise) != DIV) bad_per++;
                last_rise = cyc;
                rises++;
                q = p + 1;
                mdio_i = (q >= 48 && q <= 63) ? rsp[63 - q] : 1'b1;
            end
            prev_mdc = mdc;
            if (done) seen_done = 1'b1;
            else if (!busy) busy_gap = 1'b1;
        end
        // R3 R4 R5 R6 R7: every bit and enable seen at the PHY sample point.
        chk(bad == 0, rd ? "R6 R4 R7 frame bits/enable (read)" : "R5 R4 R7 frame bits/enable (write)", bad, 0);
        chk(rises == nbits, "R3 bit period count", rises, nbits);
        chk(bad_per == 0, "R2 mdc period", bad_per, 0);
        chk(cyc == nbits * DIV, poke ? "R9 R8 done timing with ignored start" : "R8 done timing", cyc, nbits * DIV);
        chk(!busy_gap, "R8 busy held until done", busy_gap, 0);
        if (rd) chk(rd_data == rsp, "R6 read data", rd_data, rsp);
        mdio_i = 1'b1;
        @(negedge clk);
        chk(!done && !busy, "R8 R9 single done, no second frame", {done, busy}, 0);
        chk(!mdc && !mdio_oe, "R2 R10 idle clock low, line released", {mdc, mdio_oe}, 0);
        repeat (3) @(negedge clk);
        chk(!busy && !mdc, "R9 no frame after ignored start", {busy, mdc}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog expired: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({busy, done, mdc, mdio_oe} == 4'b0, "R1 outputs during reset", {busy, done, mdc, mdio_oe}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, mdc, mdio_oe} == 4'b0, "R1 outputs after reset", {busy, done, mdc, mdio_oe}, 0);
        for (int op = 0; op < 2; op++) begin
            for (int np = 0; np < 2; np++) begin
                for (int k = 0; k < 6; k++) begin
                    logic [4:0] pa, ra;
                    logic [15:0] wd, rsp;
                    if (k == 0) begin
                        pa = 5'h00; ra = 5'h00; wd = 16'h0000; rsp = 16'h0000;
                    end else if (k == 1) begin
                        pa = 5'h1F; ra = 5'h1F; wd = 16'hFFFF; rsp = 16'hFFFF;
                    end else begin
                        pa = 5'((k * 7 + 3) % 32);
                        ra = 5'((k * 11 + op * 16) % 32);
                        wd = 16'hA5C3 ^ 16'(k * 16'h1111);
                        rsp = 16'h3C5A + 16'(k * 16'h00F1);
                    end
                    run_frame(logic'(op), pa, ra, wd, rsp, logic'(np), k == 2);
                end
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule